// File: doc/BRIEF.md
# Debug Instruction Injection Sequencer

This block drives a JTAG test access port whose data register path is already wired to the pipeline-feed scan chain of a halted processor core. It pushes instruction and data words into the core's fetch stage one at a time. Each push is a 33-bit data-register scan that ends with one TCK edge in Run-Test/Idle, and that edge clocks the word into the pipeline. On top of this single-word primitive it runs fixed register read and register write routines. The routines place each word so that it meets the fetch, decode and execute stages at the right moment.

A request carries a 4-bit register index, a direction, a 32-bit write value and a mode flag. The mode flag selects between the full-width instruction set and the compressed 16-bit instruction set. The block reports completion with a one-cycle `done` pulse. For a read, `rd_data` then holds the word the core drove out through the chain. The block assumes the TAP is parked in Run-Test/Idle, with the pipeline-feed chain selected, both at reset and between requests.

TCK runs at half the system clock rate. TMS and TDI change while TCK is low. TDO is sampled at the system clock edge that raises TCK.

Top module: `dbgi_inject_top`

## Requirements
- R1: A full injection takes 39 TCK rising edges and walks Run-Test/Idle, Select-DR, Capture-DR and Shift-DR. In Shift-DR it shifts 33 bits: first the breakpoint bit (always 0 here), then the 32-bit word, most significant bit first. TMS rises on the 33rd shift edge, and the scan then passes through Exit1-DR and Update-DR back to Run-Test/Idle.
- R2: Every injection ends with exactly one TCK rising edge taken while the TAP is in Run-Test/Idle. While the block is idle, TCK does not toggle and TMS stays low.
- R3: When the word and breakpoint bit equal those of the previous injection, the data-register scan is skipped and only one TCK edge with TMS low is issued. The first injection after reset is always scanned.
- R4: The NOP word is 0xE1A00000 in full-width mode and 0x46C046C0 in compressed mode.
- R5: A read injects a NOP, the store opcode and then four NOPs. The last NOP is always fully scanned, even when the skip rule would apply. `rd_data` becomes the 32 bits TDO presents after the first bit of that scan, taken most significant bit first.
- R6: One write pass injects a NOP, the load opcode, two NOPs, the data word and then two NOPs.
- R7: When the register index is 15 (program counter), two extra NOPs follow the data word in each write pass.
- R8: A write request runs two passes: the first with data word 0, the second with the requested value.
- R9: In full-width mode the register index is ORed into bits 15:12 of the load template 0xE59E0000 or the store template 0xE58E0000. In compressed mode the low three index bits are ORed into bits 2:0 and bits 18:16 of the load template 0x68006800 or the store template 0x60006000.
- R10: `done` is a single-cycle pulse issued after the final TCK edge of a request. `busy` is high from the cycle after an accepted `start` until `done`, and `start` is ignored while `busy` is high.
- R11: After reset, `tck`, `tms`, `tdi`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when idle |
| wr_en | input | 1 | 1 = register write, 0 = register read |
| reg_idx | input | 4 | Target register index (15 = program counter) |
| wr_data | input | 32 | Value for a write |
| compact_isa | input | 1 | 1 = compressed 16-bit instruction mode |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Value returned by the last read |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a program-counter index of 15, two refill NOPs and four trailing read NOPs. These defaults give 7-word and 9-word write passes and a 6-word read. The runs of identical NOPs inside each routine therefore exercise the scan-skip rule and the forced final scan of a read in the same routine. A behavioural TAP target in the bench follows TMS on every TCK edge. It checks each pipeline clock against a queue of expected words and scan/skip flags, which the bench builds from the routines, and it counts TCK edges between pipeline clocks.

// File: rtl/dbgi_pkg.sv
package dbgi_pkg;
  // Kind of word placed in one injection slot of a routine.
  typedef enum logic [1:0] {
    SLOT_NOP  = 2'd0,
    SLOT_OPC  = 2'd1,
    SLOT_DATA = 2'd2
  } slot_e;

  // Request-level sequencer state.
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_e;
endpackage

// File: rtl/dbgi_slot_map.sv
module dbgi_slot_map
  import dbgi_pkg::*;
#(
  parameter int STEP_W       = 4,
  parameter int PRE_DATA_NOP = 2,
  parameter int POST_NOP     = 2,
  parameter int PC_REFILL    = 2,
  parameter int READ_TAIL    = 4
) (
  input  logic              is_wr,
  input  logic              pc_tgt,
  input  logic [STEP_W-1:0] step,
  output slot_e             kind,
  output logic              last
);
  // Slot 0 is always a NOP and slot 1 carries the opcode.
  localparam int DATA_STEP = 2 + PRE_DATA_NOP;
  localparam int WR_LAST   = DATA_STEP + POST_NOP;
  localparam int WR_LAST_P = WR_LAST + PC_REFILL;
  localparam int RD_LAST   = 1 + READ_TAIL;

  always_comb begin
    kind = SLOT_NOP;
    if (step == STEP_W'(1))
      kind = SLOT_OPC;
    else if (is_wr && step == STEP_W'(DATA_STEP))
      kind = SLOT_DATA;
    if (is_wr)
      last = pc_tgt ? (step == STEP_W'(WR_LAST_P)) : (step == STEP_W'(WR_LAST));
    else
      last = (step == STEP_W'(RD_LAST));
  end
endmodule

// File: rtl/dbgi_opcode.sv
module dbgi_opcode #(
  parameter int          W          = 32,
  parameter int          IDX_W      = 4,
  parameter logic [W-1:0] WIDE_NOP  = 32'hE1A00000,
  parameter logic [W-1:0] WIDE_LOAD = 32'hE59E0000,
  parameter logic [W-1:0] WIDE_STOR = 32'hE58E0000,
  parameter logic [W-1:0] NARR_NOP  = 32'h46C046C0,
  parameter logic [W-1:0] NARR_LOAD = 32'h68006800,
  parameter logic [W-1:0] NARR_STOR = 32'h60006000,
  parameter int          WIDE_LSB   = 12,
  parameter int          NARR_LO    = 0,
  parameter int          NARR_HI    = 16,
  parameter int          NARR_IDX_W = 3
) (
  input  logic             compact,
  input  logic             is_wr,
  input  logic [IDX_W-1:0] reg_idx,
  output logic [W-1:0]     nop_word,
  output logic [W-1:0]     opc_word
);
  logic [W-1:0] wide_idx, narr_idx;
  logic [W-1:0] wide_base, narr_base;

  always_comb begin
    wide_idx  = W'(reg_idx) << WIDE_LSB;
    narr_idx  = (W'(reg_idx[NARR_IDX_W-1:0]) << NARR_LO)
              | (W'(reg_idx[NARR_IDX_W-1:0]) << NARR_HI);
    wide_base = is_wr ? WIDE_LOAD : WIDE_STOR;
    narr_base = is_wr ? NARR_LOAD : NARR_STOR;
    nop_word  = compact ? NARR_NOP : WIDE_NOP;
    opc_word  = compact ? (narr_base | narr_idx) : (wide_base | wide_idx);
  end
endmodule

// File: rtl/dbgi_shifter.sv
module dbgi_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] word,
  input  logic         brk,
  input  logic         force_scan,
  input  logic         tdo,
  output logic         tck,
  output logic         tms,
  output logic         tdi,
  output logic [W-1:0] cap_word,
  output logic         fin
);
  localparam int FRAME     = W + 1;
  localparam int SH_FIRST  = 3;
  localparam int SH_LAST   = SH_FIRST + FRAME - 1;
  localparam int SCAN_TCKS = SH_LAST + 4;
  localparam int CW        = $clog2(SCAN_TCKS + 1);

  logic          running, ph, one_tck;
  logic [CW-1:0] idx;
  logic [W:0]    sh;
  logic          last_ok, last_b;
  logic [W-1:0]  last_w;
  logic          skip;
  logic          in_shift, in_sample, tms_nxt;

  assign skip      = last_ok && (word == last_w) && (brk == last_b) && !force_scan;
  assign in_shift  = !one_tck && (idx >= CW'(SH_FIRST)) && (idx <= CW'(SH_LAST));
  assign in_sample = !one_tck && (idx >  CW'(SH_FIRST)) && (idx <= CW'(SH_LAST));

  always_comb begin
    if (one_tck)
      tms_nxt = 1'b0;
    else
      tms_nxt = (idx == '0) || (idx == CW'(SH_LAST)) || (idx == CW'(SH_LAST + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      ph       <= 1'b0;
      one_tck  <= 1'b0;
      idx      <= '0;
      sh       <= '0;
      cap_word <= '0;
      fin      <= 1'b0;
      tck      <= 1'b0;
      tms      <= 1'b0;
      tdi      <= 1'b0;
      last_ok  <= 1'b0;
      last_w   <= '0;
      last_b   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!running) begin
        if (go) begin
          running <= 1'b1;
          ph      <= 1'b0;
          idx     <= '0;
          one_tck <= skip;
          sh      <= {brk, word};
          last_ok <= 1'b1;
          last_w  <= word;
          last_b  <= brk;
        end
      end else if (!ph) begin
        tck <= 1'b0;
        tms <= tms_nxt;
        if (in_shift)
          tdi <= sh[W];
        ph <= 1'b1;
      end else begin
        tck <= 1'b1;
        ph  <= 1'b0;
        if (in_shift)
          sh <= {sh[W-1:0], 1'b0};
        if (in_sample)
          cap_word <= {cap_word[W-2:0], tdo};
        if (one_tck || idx == CW'(SCAN_TCKS - 1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end else begin
          idx <= idx + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dbgi_inject_top.sv
module dbgi_inject_top
  import dbgi_pkg::*;
#(
  parameter int W         = 32,
  parameter int IDX_W     = 4,
  parameter int PC_INDEX  = 15,
  parameter int PC_REFILL = 2,
  parameter int READ_TAIL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             compact_isa,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rd_data,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo
);
  localparam int STEP_W = $clog2(6 + PC_REFILL + READ_TAIL + 1);

  seq_e             st;
  logic [STEP_W-1:0] step;
  logic             pass2, wr_q, cmp_q;
  logic [IDX_W-1:0] reg_q;
  logic [W-1:0]     wd_q;
  slot_e            kind;
  logic             last, pc_tgt;
  logic [W-1:0]     nop_word, opc_word, inj_word, cap_word;
  logic             go, fin;

  assign pc_tgt = (reg_q == IDX_W'(PC_INDEX));
  assign go     = (st == SQ_ISSUE);
  assign busy   = (st != SQ_IDLE);

  dbgi_slot_map #(
    .STEP_W(STEP_W), .PRE_DATA_NOP(2), .POST_NOP(2),
    .PC_REFILL(PC_REFILL), .READ_TAIL(READ_TAIL)
  ) u_map (
    .is_wr(wr_q), .pc_tgt(pc_tgt), .step(step), .kind(kind), .last(last)
  );

  dbgi_opcode #(.W(W), .IDX_W(IDX_W)) u_opc (
    .compact(cmp_q), .is_wr(wr_q), .reg_idx(reg_q),
    .nop_word(nop_word), .opc_word(opc_word)
  );

  always_comb begin
    case (kind)
      SLOT_OPC:  inj_word = opc_word;
      SLOT_DATA: inj_word = pass2 ? wd_q : '0;
      default:   inj_word = nop_word;
    endcase
  end

  dbgi_shifter #(.W(W)) u_shf (
    .clk(clk), .rst(rst), .go(go), .word(inj_word), .brk(1'b0),
    .force_scan(!wr_q && last), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .cap_word(cap_word), .fin(fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      step    <= '0;
      pass2   <= 1'b0;
      wr_q    <= 1'b0;
      cmp_q   <= 1'b0;
      reg_q   <= '0;
      wd_q    <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          wr_q  <= wr_en;
          cmp_q <= compact_isa;
          reg_q <= reg_idx;
          wd_q  <= wr_data;
          step  <= '0;
          pass2 <= 1'b0;
          st    <= SQ_ISSUE;
        end
        SQ_ISSUE: st <= SQ_WAIT;
        SQ_WAIT: if (fin) begin
          if (!last) begin
            step <= step + STEP_W'(1);
            st   <= SQ_ISSUE;
          end else if (wr_q && !pass2) begin
            pass2 <= 1'b1;
            step  <= '0;
            st    <= SQ_ISSUE;
          end else begin
            if (!wr_q)
              rd_data <= cap_word;
            done <= 1'b1;
            st   <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbgi_checker.sv
module dbgi_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic tck,
  input logic tms,
  input logic tdi
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10

  AST_START_TAKES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R10

  AST_PINS_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |-> ($stable(tms) && $stable(tdi))); // R1

  AST_IDLE_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(tck)); // R2

  AST_IDLE_TMS_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tms); // R2
endmodule

bind dbgi_inject_top dbgi_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/tb_dbgi_inject_top.sv
`timescale 1ns/1ps
module tb_dbgi_inject_top;
  localparam logic [31:0] W_NOP = 32'hE1A00000, W_LD = 32'hE59E0000, W_ST = 32'hE58E0000;
  localparam logic [31:0] N_NOP = 32'h46C046C0, N_LD = 32'h68006800, N_ST = 32'h60006000;
  localparam int TAP_RTI = 0, TAP_SEL = 1, TAP_CAP = 2, TAP_SH = 3, TAP_EX1 = 4, TAP_UPD = 5;

  logic clk = 0, rst = 1, start = 0, wr_en = 0, compact_isa = 0;
  logic [3:0] reg_idx = 0;
  logic [31:0] wr_data = 0;
  logic busy, done, tck, tms, tdi, tdo;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [31:0] w; bit scanned; string tag; } exp_t;
  exp_t expq[$];
  logic [31:0] m_last;
  bit m_have = 0;

  int ts = TAP_RTI;
  logic [32:0] sr = '0, upd = '0;
  bit upd_seen = 0;
  int edges = 0;
  logic [31:0] bus_val = 0;

  assign tdo = sr[32];

  always #10 clk = ~clk;

  dbgi_inject_top dut (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .reg_idx(reg_idx),
    .wr_data(wr_data), .compact_isa(compact_isa), .busy(busy), .done(done),
    .rd_data(rd_data), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural TAP target: follows TMS, captures bus_val, records pipeline clocks.
  always @(posedge tck) begin
    edges++;
    case (ts)
      TAP_RTI: if (tms) ts = TAP_SEL;
               else begin
                 if (expq.size() == 0) chk(0, "R2 unexpected pipeline clock", {32'h0, upd[31:0]}, 64'h0);
                 else begin
                   exp_t e;
                   e = expq.pop_front();
                   chk(upd_seen == e.scanned && (!e.scanned || upd[31:0] == e.w),
                       {e.tag, " word/scan"}, {31'h0, upd_seen, upd[31:0]}, {31'h0, e.scanned, e.w});
                   chk(edges == (e.scanned ? 39 : 1), {e.tag, " R1 tck count"}, 64'(edges), e.scanned ? 64'd39 : 64'd1);
                   if (e.scanned) chk(upd[32] == 1'b0, "R1 breakpoint bit", 64'(upd[32]), 64'h0);
                 end
                 edges = 0;
                 upd_seen = 0;
               end
      TAP_SEL: if (tms) begin chk(0, "R1 IR path entered", 64'(ts), 64'(TAP_SEL)); ts = TAP_RTI; end
               else ts = TAP_CAP;
      TAP_CAP: begin sr = {1'b1, bus_val}; ts = tms ? TAP_EX1 : TAP_SH; end
      TAP_SH:  begin sr = {sr[31:0], tdi}; if (tms) ts = TAP_EX1; end
      TAP_EX1: if (tms) ts = TAP_UPD;
               else begin chk(0, "R1 pause entered", 64'(ts), 64'(TAP_UPD)); ts = TAP_RTI; end
      default: if (tms) begin chk(0, "R1 update then select", 64'(ts), 64'(TAP_RTI)); ts = TAP_RTI; end
               else begin upd = sr; upd_seen = 1; ts = TAP_RTI; end
    endcase
  end

  function automatic void expect_word(input logic [31:0] w, input bit force_it, input string tag);
    exp_t e;
    e.w = w;
    e.scanned = force_it || !(m_have && m_last == w);
    e.tag = tag;
    m_have = 1;
    m_last = w;
    expq.push_back(e);
  endfunction

  task automatic run_req(input bit wr, input bit cmp, input logic [3:0] idx,
                         input logic [31:0] val, input bit poke_mid, input string tag);
    int n = 0;
    @(negedge clk);
    wr_en = wr; compact_isa = cmp; reg_idx = idx; wr_data = val; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, {tag, " R10 busy after start"}, 64'(busy), 64'h1);
    if (poke_mid) begin
      repeat (50) @(negedge clk);
      wr_en = ~wr; reg_idx = ~idx; wr_data = ~val; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done && n < 4000) begin @(negedge clk); n++; end
    chk(done == 1'b1, {tag, " R10 done seen"}, 64'(done), 64'h1);
    chk(busy == 1'b0, {tag, " R10 idle at done"}, 64'(busy), 64'h0);
    if (!wr) chk(rd_data == bus_val, {tag, " R5 read value"}, 64'(rd_data), 64'(bus_val));
    @(negedge clk);
    chk(done == 1'b0, {tag, " R10 done one cycle"}, 64'(done), 64'h0);
    chk(expq.size() == 0, {tag, " R3 all injections seen"}, 64'(expq.size()), 64'h0);
    expq.delete();
  endtask

  task automatic do_read(input bit cmp, input logic [3:0] idx, input logic [31:0] bv, input string tag);
    logic [31:0] nop, opc;
    nop = cmp ? N_NOP : W_NOP;
    opc = cmp ? (N_ST | 32'(idx[2:0]) | (32'(idx[2:0]) << 16)) : (W_ST | (32'(idx) << 12));
    bus_val = bv;
    expect_word(nop, 0, "R5 lead NOP");
    expect_word(opc, 0, "R9 store opcode");
    for (int k = 0; k < 3; k++) expect_word(nop, 0, "R4 tail NOP");
    expect_word(nop, 1, "R5 forced final NOP");
    run_req(0, cmp, idx, 32'h0, 0, tag);
  endtask

  task automatic do_write(input bit cmp, input logic [3:0] idx, input logic [31:0] v,
                          input bit poke, input string tag);
    logic [31:0] nop, opc;
    nop = cmp ? N_NOP : W_NOP;
    opc = cmp ? (N_LD | 32'(idx[2:0]) | (32'(idx[2:0]) << 16)) : (W_LD | (32'(idx) << 12));
    for (int p = 0; p < 2; p++) begin
      expect_word(nop, 0, "R6 lead NOP");
      expect_word(opc, 0, "R9 load opcode");
      expect_word(nop, 0, "R6 NOP");
      expect_word(nop, 0, "R6 NOP");
      expect_word(p == 0 ? 32'h0 : v, 0, "R8 data word");
      if (idx == 4'd15) begin
        expect_word(nop, 0, "R7 refill NOP");
        expect_word(nop, 0, "R7 refill NOP");
      end
      expect_word(nop, 0, "R6 trail NOP");
      expect_word(nop, 0, "R6 trail NOP");
    end
    run_req(1, cmp, idx, v, poke, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({tck, tms, tdi, busy, done} == 5'b0, "R11 reset outputs", 64'({tck, tms, tdi, busy, done}), 64'h0);
    repeat (5) @(negedge clk);
    chk(edges == 0, "R2 no tck while idle", 64'(edges), 64'h0);
    do_read(0, 4'd3, 32'hA5A51234, "wide read r3");
    do_write(0, 4'd5, 32'h12345678, 0, "wide write r5");
    do_write(0, 4'd15, 32'h00008000, 0, "wide write pc");
    do_read(1, 4'd6, 32'h5A5AF00F, "narrow read r6");
    do_write(1, 4'd2, 32'hDEADBEEF, 1, "narrow write r2 with ignored start");
    do_read(1, 4'd10, 32'h80000001, "narrow read masked index");
    do_write(0, 4'd0, W_NOP, 0, "wide write nop-valued data");
    do_read(0, 4'd14, 32'hFFFFFFFE, "wide read r14");
    repeat (10) @(negedge clk);
    chk(edges == 0, "R2 quiet after done", 64'(edges), 64'h0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired R10 actual=busy expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule